// File: doc/BRIEF.md
# Codec mute and power-down sequencer

This controller takes an audio codec into and out of power-down without an audible click. Whenever power-down changes, the converter output shifts its DC level. The sequencer hides that step behind an external mute. On a sleep request it raises mute, waits, and raises codec power-down. If clock gating is allowed at that point, it then stops the codec system clock. On a wake request it works in the opposite order. It restores the clock if it was stopped, waits, releases power-down, waits again, and only then drops mute.

A codec whose clock stops while it is powered down loses all of its mode settings. The sequencer keeps a sticky record of every gated period. While that record is set, it runs a register-rewrite handshake after power-down is released. Mute stays asserted until the handshake is acknowledged.

Each wait lasts a programmable settle count of controller clock cycles. A settle count of zero selects a built-in default of 1024 cycles. A wake request that arrives during entry is remembered and acted on once the powered-down state is reached. The controller itself runs on a free-running clock; `clk_en` gates only the codec clock.

Top module: `codec_pwr_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no requests: mute=0, pdn=0, clk_en=1, busy=0, rw_req=0.
- R2: A sleep request sampled while idle raises mute and busy at that clock edge. pdn rises S edges later, where S is the effective settle count. pdn is never high while mute is low.
- R3: If gate_allow is high when the power-down settle ends, clk_en falls S edges after pdn rose, and busy falls on the same edge. clk_en is low only while pdn is high.
- R4: A wake request sampled in the powered-down state restarts the clock at that edge when it was stopped. pdn falls S edges later, or at that same edge when the clock kept running. With no rewrite pending, mute and busy fall S edges after pdn fell. mute falls only after pdn is low.
- R5: If the clock was gated, rw_req rises S edges after pdn fell. It stays high until rw_done is sampled high. mute, rw_req and busy fall at the edge where rw_done is sampled. The gated record clears only on that acknowledge.
- R6: When the clock was not gated, the exit never raises rw_req, and clk_en stays high throughout.
- R7: A wake request sampled during entry does not shorten entry. pdn still rises at the normal edge, and the powered-down state is held for exactly one cycle with busy low. The exit then starts by itself.
- R8: busy is high in every entry and exit step, and low when idle and when powered down.
- R9: A settle count input of 0 gives S=1024. Any other value v gives S=v.
- R10: A wake request while idle, and a sleep request while powered down or during exit, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| settle_cycles | input | CNT_W | Settle length per step; 0 selects the default |
| sleep_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| gate_allow | input | 1 | Permit stopping the codec clock once powered down |
| rw_done | input | 1 | Acknowledge of the mode-register rewrite |
| mute | output | 1 | External mute control, high = muted |
| pdn | output | 1 | Codec power-down, high = powered down |
| clk_en | output | 1 | Codec system clock enable |
| busy | output | 1 | High while a sequence is in progress |
| rw_req | output | 1 | Request to rewrite the codec mode registers |

## Verification
Two functions can land on the same cycle. The first is a wake request, which must be captured in the pending flag. The second is the entry sequence, which keeps counting toward power-down while the wake is pending. The bench drives the wake one cycle after the sleep, while mute is settling. It then checks three things: pdn rises at the unshortened edge, busy drops for exactly one powered-down cycle, and the clock returns on the next edge. A second collision is a sleep request placed inside the exit's power-up settle. The bench judges that case by mute falling on schedule and by no new entry starting afterwards.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_IN_MUTE   = 3'd1,
    ST_IN_PDN    = 3'd2,
    ST_DOWN_CLK  = 3'd3,
    ST_DOWN_GATE = 3'd4,
    ST_OUT_CLK   = 3'd5,
    ST_OUT_PDN   = 3'd6,
    ST_OUT_REG   = 3'd7
  } seq_state_e;

  // Effective settle length: zero selects the default.
  function automatic int unsigned settle_len(input int unsigned raw,
                                             input int unsigned dflt);
    return (raw == 0) ? dflt : raw;
  endfunction

  function automatic logic is_transit(input seq_state_e s);
    return !(s == ST_RUN || s == ST_DOWN_CLK || s == ST_DOWN_GATE);
  endfunction

endpackage

// File: rtl/cps_settle_timer.sv
module cps_settle_timer #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_SETTLE = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] settle_raw,
  output logic             done
);
  import cps_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(settle_len(32'(settle_raw), DEF_SETTLE) - 1);
  assign done     = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= load_val;
    else if (!done)      cnt_q <= cnt_q - 1'b1;
  end

  AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/cps_stale_flag.sv
module cps_stale_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic stale
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stale <= 1'b0;
    else if (set_evt) stale <= 1'b1;
    else if (clr_evt) stale <= 1'b0;
  end

  AST_STALE_CLEARS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stale) |-> $past(clr_evt)); // R5

endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic gate_allow,
  input  logic tmr_done,
  input  logic stale,
  input  logic rw_done,
  output logic tmr_start,
  output logic gate_evt,
  output logic ack_evt,
  output logic mute,
  output logic pdn,
  output logic clk_en,
  output logic busy,
  output logic rw_req
);
  import cps_pkg::*;

  seq_state_e state_q, state_d;
  logic       wake_pend_q;
  logic       entering, leave_down, wake_seen;

  assign entering   = (state_q == ST_IN_MUTE) || (state_q == ST_IN_PDN);
  assign wake_seen  = wake_req || wake_pend_q;
  assign leave_down = (state_q == ST_DOWN_CLK || state_q == ST_DOWN_GATE) && wake_seen;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (sleep_req) state_d = ST_IN_MUTE;
      ST_IN_MUTE:   if (tmr_done)  state_d = ST_IN_PDN;
      ST_IN_PDN:    if (tmr_done)  state_d = gate_allow ? ST_DOWN_GATE : ST_DOWN_CLK;
      ST_DOWN_CLK:  if (wake_seen) state_d = ST_OUT_PDN;
      ST_DOWN_GATE: if (wake_seen) state_d = ST_OUT_CLK;
      ST_OUT_CLK:   if (tmr_done)  state_d = ST_OUT_PDN;
      ST_OUT_PDN:   if (tmr_done)  state_d = stale ? ST_OUT_REG : ST_RUN;
      ST_OUT_REG:   if (rw_done)   state_d = ST_RUN;
      default:                     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      wake_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (leave_down)                wake_pend_q <= 1'b0;
      else if (entering && wake_req) wake_pend_q <= 1'b1;
    end
  end

  // Named events for the timer, the stale record and the assertions.
  assign tmr_start = (state_d != state_q);
  assign gate_evt  = (state_q == ST_IN_PDN) && (state_d == ST_DOWN_GATE);
  assign ack_evt   = (state_q == ST_OUT_REG) && rw_done;

  assign mute   = (state_q != ST_RUN);
  assign pdn    = (state_q == ST_IN_PDN) || (state_q == ST_DOWN_CLK) ||
                  (state_q == ST_DOWN_GATE) || (state_q == ST_OUT_CLK);
  assign clk_en = (state_q != ST_DOWN_GATE);
  assign busy   = is_transit(state_q);
  assign rw_req = (state_q == ST_OUT_REG);

  AST_PDN_UNDER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |-> mute); // R2
  AST_PDN_RISES_AFTER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdn) |-> $past(mute)); // R2
  AST_CLK_OFF_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (pdn && $past(pdn))); // R3
  AST_CLK_BACK_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pdn) |-> (clk_en && $past(clk_en))); // R4
  AST_UNMUTE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> (!pdn && $past(!pdn))); // R4
  AST_UNMUTE_NEEDS_FRESH_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> !stale); // R5
  AST_RW_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_req && !rw_done) |=> rw_req); // R5
  AST_RW_ONLY_AFTER_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_req) |-> $past(stale)); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rw_req); // R8

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_SETTLE = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             gate_allow,
  input  logic             rw_done,
  output logic             mute,
  output logic             pdn,
  output logic             clk_en,
  output logic             busy,
  output logic             rw_req
);
  logic tmr_start, tmr_done, gate_evt, ack_evt, stale;

  cps_settle_timer #(.CNT_W(CNT_W), .DEF_SETTLE(DEF_SETTLE)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .settle_raw(settle_cycles), .done(tmr_done)
  );

  cps_stale_flag stale_i (
    .clk(clk), .rst_n(rst_n), .set_evt(gate_evt),
    .clr_evt(ack_evt), .stale(stale)
  );

  cps_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .gate_allow(gate_allow), .tmr_done(tmr_done), .stale(stale),
    .rw_done(rw_done), .tmr_start(tmr_start), .gate_evt(gate_evt),
    .ack_evt(ack_evt), .mute(mute), .pdn(pdn), .clk_en(clk_en),
    .busy(busy), .rw_req(rw_req)
  );

endmodule

// File: tb/codec_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb_top;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] settle_cycles = 16'(S);
  logic        sleep_req = 1'b0, wake_req = 1'b0, gate_allow = 1'b0, rw_done = 1'b0;
  logic        mute, pdn, clk_en, busy, rw_req;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  codec_pwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
    .sleep_req(sleep_req), .wake_req(wake_req), .gate_allow(gate_allow),
    .rw_done(rw_done), .mute(mute), .pdn(pdn), .clk_en(clk_en),
    .busy(busy), .rw_req(rw_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic m, input logic p,
                         input logic c, input logic b, input logic r);
    chk({tag, " mute"}, mute, m);
    chk({tag, " pdn"}, pdn, p);
    chk({tag, " clk_en"}, clk_en, c);
    chk({tag, " busy"}, busy, b);
    chk({tag, " rw_req"}, rw_req, r);
  endtask

  // Gated entry, rewrite handshake on exit (R2 R3 R4 R5 R8)
  task automatic t_gated();
    sleep_req = 1; gate_allow = 1;
    step(1); sleep_req = 0;
    chk_all("R2 mute first", 1, 0, 1, 1, 0);
    step(S - 1); chk("R2 pdn waits settle", pdn, 0);
    step(1);     chk_all("R2 pdn raised", 1, 1, 1, 1, 0);
    step(S - 1); chk("R3 clock kept during settle", clk_en, 1);
    step(1);     chk_all("R3 R8 gated and down", 1, 1, 0, 0, 0);
    step(5);     chk_all("R8 down stays", 1, 1, 0, 0, 0);
    wake_req = 1; step(1); wake_req = 0;
    chk_all("R4 clock restored first", 1, 1, 1, 1, 0);
    step(S - 1); chk("R4 pdn held during clock settle", pdn, 1);
    step(1);     chk_all("R4 pdn released", 1, 0, 1, 1, 0);
    step(S - 1); chk("R5 no rewrite yet", rw_req, 0);
    step(1);     chk_all("R5 rewrite requested", 1, 0, 1, 1, 1);
    step(10);    chk_all("R5 rewrite held", 1, 0, 1, 1, 1);
    rw_done = 1; step(1); rw_done = 0;
    chk_all("R5 unmute on ack", 0, 0, 1, 0, 0);
  endtask

  // Clock kept running: no rewrite (R4 R6 R9 via s)
  task automatic t_ungated(input int s, input string tag);
    sleep_req = 1; gate_allow = 0;
    step(1); sleep_req = 0;
    step(s - 1); chk({tag, " pdn still low"}, pdn, 0);
    step(1);     chk({tag, " pdn high"}, pdn, 1);
    step(s);     chk_all({tag, " R6 down clock on"}, 1, 1, 1, 0, 0);
    wake_req = 1; step(1); wake_req = 0;
    chk_all({tag, " R4 pdn released at wake"}, 1, 0, 1, 1, 0);
    for (int i = 0; i < s - 1; i++) begin
      step(1);
      if (rw_req !== 1'b0 || mute !== 1'b1) chk({tag, " R6 exit hold"}, rw_req, 0);
    end
    n_chk++;
    step(1); chk_all({tag, " R4 R6 unmuted"}, 0, 0, 1, 0, 0);
  endtask

  // Wake during entry is held (R7)
  task automatic t_pending();
    sleep_req = 1; gate_allow = 1;
    step(1); sleep_req = 0; wake_req = 1;
    step(1); wake_req = 0;
    chk_all("R7 entry continues", 1, 0, 1, 1, 0);
    step(S - 2); chk("R7 pdn not early", pdn, 0);
    step(1);     chk("R7 pdn on time", pdn, 1);
    step(S);     chk_all("R7 one down cycle", 1, 1, 0, 0, 0);
    step(1);     chk_all("R7 exit starts", 1, 1, 1, 1, 0);
    step(S);     chk("R7 pdn released", pdn, 0);
    step(S);     chk("R7 rewrite requested", rw_req, 1);
    rw_done = 1; step(1); rw_done = 0;
    chk_all("R7 back to run", 0, 0, 1, 0, 0);
  endtask

  // Requests in the wrong state (R10)
  task automatic t_ignored();
    wake_req = 1; step(1); wake_req = 0;
    step(2); chk_all("R10 wake while idle", 0, 0, 1, 0, 0);
    sleep_req = 1; gate_allow = 0; step(1); sleep_req = 0;
    step(2 * S);
    sleep_req = 1; step(1); sleep_req = 0;
    chk_all("R10 sleep while down", 1, 1, 1, 0, 0);
    wake_req = 1; step(1); wake_req = 0;
    sleep_req = 1; step(1); sleep_req = 0;
    step(S - 2); chk("R10 still muted in exit", mute, 1);
    step(1);     chk_all("R10 exit on time", 0, 0, 1, 0, 0);
    step(3);     chk_all("R10 no new entry", 0, 0, 1, 0, 0);
  endtask

  initial begin
    step(3);
    chk_all("R1 in reset", 0, 0, 1, 0, 0);
    rst_n = 1;
    step(2);
    chk_all("R1 after reset", 0, 0, 1, 0, 0);
    t_gated();
    t_ungated(S, "S4");
    t_pending();
    t_ignored();
    settle_cycles = 16'd0;
    t_ungated(1024, "R9 default");
    settle_cycles = 16'd1;
    t_ungated(1, "R9 one");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule